// File: doc/BRIEF.md
# Receive Scatter DMA for a Serial Channel

This block takes a received serial frame, arriving as a byte stream with an end marker, and spreads it across a chain of receive descriptors held in system memory. Each descriptor is four 32-bit words at consecutive addresses. Offset 0 holds the buffer room in bits 31:16 and the filled byte count in bits 15:0. Offset 4 holds status: bit 31 is the ownership flag, bit 17 marks the first descriptor of a frame and bit 16 marks the last. Offset 8 holds the link to the next descriptor, and offset 12 holds the buffer address.

The whole frame is first gathered in an internal byte store, so its length is known before any descriptor is closed. The engine then walks the chain from the channel's current receive pointer. For each descriptor it checks ownership, copies as many bytes as fit, and writes the descriptor back. The first descriptor is held back and written only once the whole frame has landed. A successful frame advances the pointer and pulses a buffer-ready cause. A broken chain pulses an error cause and leaves the pointer where it was.

The channel mode is the low 3-bit field of the channel configuration. Value 0 is HDLC and value 4 is UART. Any other value is a plain framed mode.

Top module: `rxsg_rx_scatter`

## Requirements
- R1: A frame longer than MAX_PKT bytes (default 64) is cut to its first MAX_PKT bytes. The extra bytes are accepted and discarded.
- R2: If the receive pointer is zero when a frame ends, cause_rxerr pulses for one cycle, no memory access is made and the pointer stays zero.
- R3: If a descriptor in the chain has bit 31 of its status word clear, the frame is abandoned and cause_rxerr pulses. No byte is written into that descriptor's buffer, and the pointer keeps its value.
- R4: Each descriptor receives min(word0[31:16], bytes still to place) bytes, written to consecutive addresses from its buffer address. That count is ORed into word0[15:0].
- R5: Every descriptor visited in a frame is written back with status bit 31 cleared.
- R6: The descriptor holding the final byte gets status bit 16 set. In HDLC mode (mode 0), its word0 is also increased by 2.
- R7: A descriptor other than the first is written back (word0, then status) right after its bytes. The first descriptor is written back last, with status bit 17 set.
- R8: If a descriptor's link is zero while bytes remain, cause_rxerr pulses, the pointer keeps its value and the first descriptor is not written back.
- R9: On success, the pointer becomes the link word of the last descriptor used, and cause_rxbuf pulses for one cycle. The two causes never pulse together.
- R10: In UART mode (mode 4), every accepted byte is a complete one-byte frame, whatever in_last says.
- R11: A ptr_load pulse sets the receive pointer to ptr_wdata, and rx_ptr shows it on the next cycle.
- R12: in_ready is high only while the engine is gathering a frame. It is low from the cycle after the frame end until the cause pulse has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Received byte present |
| in_data | input | 8 | Received byte |
| in_last | input | 1 | Byte ends the frame |
| in_ready | output | 1 | Engine accepts bytes |
| cfg_mode | input | 3 | Channel mode field (0 HDLC, 4 UART) |
| ptr_load | input | 1 | Write the receive pointer |
| ptr_wdata | input | ADDR_W | New receive pointer |
| rx_ptr | output | ADDR_W | Current receive descriptor pointer |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_byte | output | 1 | Write of one byte (wdata[7:0]) rather than a word |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Read data |
| cause_rxbuf | output | 1 | Frame stored pulse |
| cause_rxerr | output | 1 | Receive DMA error pulse |

## Verification
A wrong copy count or a remaining-byte count that drifts would show up in the written-back word0 and in the buffer contents. The bench checks these as soon as the cause pulse arrives, a few hundred cycles after the frame end at most. A wrong ownership or link decision shows at the ports as the wrong cause pulse, a moved pointer, or a first descriptor that should not have been touched. A lost first-descriptor holding register shows as missing first or last flags in the status word. The sweeps over frame length put the frame end on every buffer boundary of a small chain.

// File: rtl/rxsg_pkg.sv
package rxsg_pkg;
  localparam int OWN_BIT   = 31;
  localparam int FIRST_BIT = 17;
  localparam int LAST_BIT  = 16;
  localparam logic [2:0] MODE_HDLC = 3'd0;
  localparam logic [2:0] MODE_UART = 3'd4;
  localparam logic [15:0] CRC_PAD = 16'd2;

  typedef enum logic [3:0] {
    ST_COLLECT, ST_RD_SIZE, ST_RD_STAT, ST_RD_NEXT, ST_RD_BUF,
    ST_DATA, ST_WB_SIZE, ST_WB_STAT, ST_NEXT,
    ST_FIN_SIZE, ST_FIN_STAT, ST_DONE, ST_ERR
  } rx_state_e;

  // bytes that go into one buffer
  function automatic logic [15:0] copy_len(logic [15:0] room, logic [15:0] left);
    return (room < left) ? room : left;
  endfunction

  // new size/count word for a descriptor
  function automatic logic [31:0] size_word(logic [31:0] w0, logic [15:0] cnt,
                                            logic last, logic hdlc);
    logic [31:0] v;
    v = w0 | {16'h0, cnt};
    if (last && hdlc) v = v + {16'h0, CRC_PAD};
    return v;
  endfunction

  // new status word for a descriptor
  function automatic logic [31:0] stat_word(logic [31:0] w1, logic last, logic first);
    logic [31:0] v;
    v = w1;
    v[OWN_BIT] = 1'b0;
    if (last)  v[LAST_BIT]  = 1'b1;
    if (first) v[FIRST_BIT] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/rxsg_fifo.sv
module rxsg_fifo #(
  parameter int DEPTH = 64,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [7:0]    din,
  input  logic          pop,
  input  logic          flush,
  output logic [7:0]    dout,
  output logic [CW-1:0] count,
  output logic          full
);
  logic [7:0]    store [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && (cnt_q != '0);
  assign dout    = store[rd_q];
  assign count   = cnt_q;

  function automatic logic [PW-1:0] wrap_inc(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) store[wr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= wrap_inc(wr_q);
      if (do_pop)  rd_q <= wrap_inc(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) pop |-> cnt_q != '0); // R1
  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (rst) cnt_q <= CW'(DEPTH)); // R1
endmodule

// File: rtl/rxsg_desc_update.sv
module rxsg_desc_update (
  input  logic [31:0] w0,
  input  logic [31:0] w1,
  input  logic [15:0] cnt,
  input  logic        is_last,
  input  logic        is_first,
  input  logic        hdlc,
  output logic [31:0] nw0,
  output logic [31:0] nw1
);
  import rxsg_pkg::*;
  assign nw0 = size_word(w0, cnt, is_last, hdlc);
  assign nw1 = stat_word(w1, is_last, is_first);
endmodule

// File: rtl/rxsg_rx_scatter.sv
module rxsg_rx_scatter #(
  parameter int MAX_PKT = 64,
  parameter int ADDR_W  = 32,
  localparam int CNT_W  = $clog2(MAX_PKT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              in_ready,
  input  logic [2:0]        cfg_mode,
  input  logic              ptr_load,
  input  logic [ADDR_W-1:0] ptr_wdata,
  output logic [ADDR_W-1:0] rx_ptr,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_byte,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              cause_rxbuf,
  output logic              cause_rxerr
);
  import rxsg_pkg::*;

  rx_state_e         st;
  logic [ADDR_W-1:0] cur_q, start_q, next_q, bufp_q, ptr_q;
  logic [31:0]       w0_q, w1_q, f0_q, f1_q, nw0, nw1;
  logic [CNT_W-1:0]  cp_q, cnt_q, fifo_cnt, cp_calc;
  logic              last_q, first_q;
  logic              is_hdlc, is_uart, collecting;
  logic              fifo_push, fifo_pop, fifo_flush, fifo_full;
  logic [7:0]        fifo_dout;

  // named internal events
  logic ev_frame_end, ev_data_wr, ev_own_fail, ev_stat_wb;

  assign is_hdlc      = (cfg_mode == MODE_HDLC);
  assign is_uart      = (cfg_mode == MODE_UART);
  assign collecting   = (st == ST_COLLECT);
  assign in_ready     = collecting;
  assign ev_frame_end = collecting && in_valid && (in_last || is_uart);
  assign fifo_push    = collecting && in_valid;
  assign ev_data_wr   = (st == ST_DATA) && (cnt_q != cp_q);
  assign fifo_pop     = ev_data_wr && mem_ack;
  assign fifo_flush   = (st == ST_ERR);
  assign ev_own_fail  = (st == ST_RD_STAT) && mem_ack && !mem_rdata[OWN_BIT];
  assign cp_calc      = CNT_W'(copy_len(w0_q[31:16], 16'(fifo_cnt)));
  assign cause_rxbuf  = (st == ST_DONE);
  assign cause_rxerr  = (st == ST_ERR);
  assign rx_ptr       = ptr_q;

  rxsg_fifo #(.DEPTH(MAX_PKT)) i_fifo (
    .clk(clk), .rst(rst), .push(fifo_push), .din(in_data),
    .pop(fifo_pop), .flush(fifo_flush), .dout(fifo_dout),
    .count(fifo_cnt), .full(fifo_full)
  );

  rxsg_desc_update i_upd (
    .w0(w0_q), .w1(w1_q), .cnt(16'(cp_q)), .is_last(last_q),
    .is_first(first_q), .hdlc(is_hdlc), .nw0(nw0), .nw1(nw1)
  );

  // receive pointer register
  always_ff @(posedge clk) begin
    if (rst)                ptr_q <= '0;
    else if (ptr_load)      ptr_q <= ptr_wdata;
    else if (st == ST_DONE) ptr_q <= next_q;
  end

  // descriptor walk
  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_COLLECT;
      cur_q   <= '0;
      start_q <= '0;
      next_q  <= '0;
      bufp_q  <= '0;
      w0_q    <= '0;
      w1_q    <= '0;
      f0_q    <= '0;
      f1_q    <= '0;
      cp_q    <= '0;
      cnt_q   <= '0;
      last_q  <= 1'b0;
      first_q <= 1'b0;
    end else begin
      case (st)
        ST_COLLECT: if (ev_frame_end) begin
          if (ptr_q == '0) st <= ST_ERR;
          else begin
            cur_q   <= ptr_q;
            start_q <= ptr_q;
            first_q <= 1'b1;
            st      <= ST_RD_SIZE;
          end
        end
        ST_RD_SIZE: if (mem_ack) begin
          w0_q <= mem_rdata;
          st   <= ST_RD_STAT;
        end
        ST_RD_STAT: if (mem_ack) begin
          w1_q <= mem_rdata;
          st   <= ev_own_fail ? ST_ERR : ST_RD_NEXT;
        end
        ST_RD_NEXT: if (mem_ack) begin
          next_q <= mem_rdata[ADDR_W-1:0];
          st     <= ST_RD_BUF;
        end
        ST_RD_BUF: if (mem_ack) begin
          bufp_q <= mem_rdata[ADDR_W-1:0];
          cp_q   <= cp_calc;
          last_q <= (cp_calc == fifo_cnt);
          cnt_q  <= '0;
          st     <= ST_DATA;
        end
        ST_DATA: begin
          if (cnt_q == cp_q) begin
            if (first_q) begin
              f0_q <= nw0;
              f1_q <= nw1;
              st   <= ST_NEXT;
            end else begin
              st <= ST_WB_SIZE;
            end
          end else if (mem_ack) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_WB_SIZE: if (mem_ack) st <= ST_WB_STAT;
        ST_WB_STAT: if (mem_ack) st <= ST_NEXT;
        ST_NEXT: begin
          if (last_q) st <= ST_FIN_SIZE;
          else if (next_q == '0) st <= ST_ERR;
          else begin
            cur_q   <= next_q;
            first_q <= 1'b0;
            st      <= ST_RD_SIZE;
          end
        end
        ST_FIN_SIZE: if (mem_ack) st <= ST_FIN_STAT;
        ST_FIN_STAT: if (mem_ack) st <= ST_DONE;
        ST_DONE:     st <= ST_COLLECT;
        ST_ERR:      st <= ST_COLLECT;
        default:     st <= ST_COLLECT;
      endcase
    end
  end

  // memory request mux
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_byte  = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (st)
      ST_RD_SIZE:  begin mem_req = 1'b1; mem_addr = cur_q; end
      ST_RD_STAT:  begin mem_req = 1'b1; mem_addr = cur_q + ADDR_W'(4); end
      ST_RD_NEXT:  begin mem_req = 1'b1; mem_addr = cur_q + ADDR_W'(8); end
      ST_RD_BUF:   begin mem_req = 1'b1; mem_addr = cur_q + ADDR_W'(12); end
      ST_DATA: begin
        mem_req   = ev_data_wr;
        mem_we    = 1'b1;
        mem_byte  = 1'b1;
        mem_addr  = bufp_q + ADDR_W'(cnt_q);
        mem_wdata = {24'h0, fifo_dout};
      end
      ST_WB_SIZE:  begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = cur_q; mem_wdata = nw0; end
      ST_WB_STAT:  begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = cur_q + ADDR_W'(4); mem_wdata = nw1; end
      ST_FIN_SIZE: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = start_q; mem_wdata = f0_q; end
      ST_FIN_STAT: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = start_q + ADDR_W'(4); mem_wdata = f1_q; end
      default: ;
    endcase
  end

  assign ev_stat_wb = mem_req && mem_we && ((st == ST_WB_STAT) || (st == ST_FIN_STAT));

  AST_BYTE_WRITE_OWNED: assert property (@(posedge clk) disable iff (rst) ev_data_wr |-> w1_q[OWN_BIT]); // R3
  AST_COPY_BOUND: assert property (@(posedge clk) disable iff (rst) ev_data_wr |-> (cnt_q < cp_q) && (fifo_cnt != '0)); // R4
  AST_STAT_OWN_CLEARED: assert property (@(posedge clk) disable iff (rst) ev_stat_wb |-> !mem_wdata[OWN_BIT]); // R5
  AST_FIRST_FLAG_FINAL: assert property (@(posedge clk) disable iff (rst) (st == ST_FIN_STAT) |-> mem_wdata[FIRST_BIT]); // R7
  AST_CAUSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(cause_rxbuf && cause_rxerr)); // R9
  AST_PTR_MOVE_SOURCE: assert property (@(posedge clk) disable iff (rst) (ptr_q != $past(ptr_q)) |-> ($past(ptr_load) || $past(cause_rxbuf))); // R11
  AST_READY_AFTER_END: assert property (@(posedge clk) disable iff (rst) ev_frame_end |=> !in_ready); // R12
  AST_NO_ACCESS_WHILE_COLLECT: assert property (@(posedge clk) disable iff (rst) in_ready |-> !mem_req); // R12
endmodule

// File: tb/test_rxsg_rx_scatter.sv
module test_rxsg_rx_scatter;
  localparam int MAXP = 64;
  localparam int DBASE = 'h100;
  localparam int BBASE = 'h400;
  localparam logic [31:0] OWN = 32'h8000_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        in_valid = 0, in_last = 0, in_ready;
  logic [7:0]  in_data = 0;
  logic [2:0]  cfg_mode = 3'd2;
  logic        ptr_load = 0;
  logic [31:0] ptr_wdata = 0, rx_ptr;
  logic        mem_req, mem_we, mem_byte, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        cause_rxbuf, cause_rxerr;

  rxsg_rx_scatter #(.MAX_PKT(MAXP), .ADDR_W(32)) i_rxsg_rx_scatter (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_ready(in_ready), .cfg_mode(cfg_mode), .ptr_load(ptr_load), .ptr_wdata(ptr_wdata),
    .rx_ptr(rx_ptr), .mem_req(mem_req), .mem_we(mem_we), .mem_byte(mem_byte),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .cause_rxbuf(cause_rxbuf), .cause_rxerr(cause_rxerr)
  );

  logic [7:0] mem [0:2047];
  int n_req = 0;
  int n_checks = 0;
  int n_fail = 0;

  // memory model: acknowledges one cycle after a request
  always @(posedge clk) begin
    if (rst) mem_ack <= 1'b0;
    else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        mem_ack <= 1'b1;
        n_req = n_req + 1;
        if (mem_we) begin
          if (mem_byte) mem[mem_addr[10:0]] <= mem_wdata[7:0];
          else begin
            mem[mem_addr[10:0]]          <= mem_wdata[7:0];
            mem[11'(mem_addr[10:0] + 1)] <= mem_wdata[15:8];
            mem[11'(mem_addr[10:0] + 2)] <= mem_wdata[23:16];
            mem[11'(mem_addr[10:0] + 3)] <= mem_wdata[31:24];
          end
        end else begin
          mem_rdata <= {mem[11'(mem_addr[10:0] + 3)], mem[11'(mem_addr[10:0] + 2)],
                        mem[11'(mem_addr[10:0] + 1)], mem[mem_addr[10:0]]};
        end
      end
    end
  end

  task automatic wr32(int a, logic [31:0] v);
    mem[a] = v[7:0]; mem[a+1] = v[15:8]; mem[a+2] = v[23:16]; mem[a+3] = v[31:24];
  endtask

  function automatic logic [31:0] rd32(int a);
    return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic load_ptr(logic [31:0] p);
    @(negedge clk);
    ptr_load = 1; ptr_wdata = p;
    @(negedge clk);
    ptr_load = 0;
    chk(rx_ptr == p, "R11 pointer load", rx_ptr, p);
  endtask

  task automatic push_byte(logic [7:0] d, logic l);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_data = d; in_last = l;
    @(negedge clk);
    in_valid = 0; in_last = 0;
  endtask

  task automatic wait_cause(output bit b, output bit e);
    b = 0; e = 0;
    for (int t = 0; t < 5000; t++) begin
      b = cause_rxbuf; e = cause_rxerr;
      if (b || e) break;
      @(negedge clk);
    end
    if (!(b || e)) chk(0, "cause timeout", 0, 1);
    @(negedge clk);
  endtask

  function automatic int daddr(int k); return DBASE + 16 * k; endfunction
  function automatic int baddr(int k); return BBASE + 64 * k; endfunction
  function automatic logic [7:0] pat(int l, int i); return 8'(l * 7 + i * 3 + 1); endfunction

  task automatic build_chain(int sz[4]);
    for (int k = 0; k < 4; k++) begin
      wr32(daddr(k), 32'(sz[k]) << 16);
      wr32(daddr(k) + 4, OWN);
      wr32(daddr(k) + 8, (k < 3) ? 32'(daddr(k + 1)) : 32'h0);
      wr32(daddr(k) + 12, 32'(baddr(k)));
      for (int i = 0; i < 64; i++) mem[baddr(k) + i] = 8'hEE;
    end
  endtask

  task automatic send_frame(int l);
    for (int i = 0; i < l; i++) push_byte(pat(l, i), i == l - 1);
  endtask

  // one frame through a four-descriptor chain with expected results computed here
  task automatic run_chain(int l, bit hdlc, int sz[4]);
    bit b, e;
    int lt, total, rem, cp, ok_bytes;
    logic [31:0] exp0, exp1;
    build_chain(sz);
    cfg_mode = hdlc ? 3'd0 : 3'd2;
    load_ptr(DBASE);
    send_frame(l);
    chk(!in_ready, "R12 ready low after frame end", 32'(in_ready), 0);
    wait_cause(b, e);
    lt = (l > MAXP) ? MAXP : l;
    total = sz[0] + sz[1] + sz[2] + sz[3];
    if (lt <= total) begin
      chk(b && !e, "R9 buffer cause", {30'h0, b, e}, 32'h2);
      rem = lt;
      for (int k = 0; k < 4; k++) begin
        cp = (sz[k] < rem) ? sz[k] : rem;
        rem -= cp;
        exp0 = ((32'(sz[k]) << 16) | 32'(cp)) + ((rem == 0 && hdlc) ? 32'd2 : 32'd0);
        exp1 = ((rem == 0) ? 32'h1_0000 : 32'h0) | ((k == 0) ? 32'h2_0000 : 32'h0);
        chk(rd32(daddr(k)) == exp0, "R4 R6 size word", rd32(daddr(k)), exp0);
        chk(rd32(daddr(k) + 4) == exp1, "R5 R7 status word", rd32(daddr(k) + 4), exp1);
        ok_bytes = 1;
        for (int i = 0; i < cp; i++)
          if (mem[baddr(k) + i] != pat(l, lt - rem - cp + i)) ok_bytes = 0;
        chk(ok_bytes == 1, "R4 R1 buffer bytes", 32'(ok_bytes), 1);
        if (cp < sz[k])
          chk(mem[baddr(k) + cp] == 8'hEE, "R4 copy bound", 32'(mem[baddr(k) + cp]), 32'hEE);
        if (rem == 0) begin
          exp0 = (k < 3) ? 32'(daddr(k + 1)) : 32'h0;
          chk(rx_ptr == exp0, "R9 pointer advance", rx_ptr, exp0);
          break;
        end
      end
    end else begin
      chk(e && !b, "R8 error cause", {30'h0, b, e}, 32'h1);
      chk(rx_ptr == DBASE, "R8 pointer held", rx_ptr, DBASE);
      chk(rd32(daddr(0) + 4) == OWN, "R8 first not written", rd32(daddr(0) + 4), OWN);
      chk(rd32(daddr(0)) == (32'(sz[0]) << 16), "R8 first size kept", rd32(daddr(0)), 32'(sz[0]) << 16);
    end
  endtask

  initial begin
    bit b, e;
    int r0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(rx_ptr == 0, "reset pointer", rx_ptr, 0);
    chk(in_ready == 1, "R12 reset ready", 32'(in_ready), 1);
    chk(!mem_req && !cause_rxbuf && !cause_rxerr, "reset outputs",
        {29'h0, mem_req, cause_rxbuf, cause_rxerr}, 0);

    // R2: zero pointer
    r0 = n_req;
    send_frame(3);
    wait_cause(b, e);
    chk(e && !b, "R2 error cause", {30'h0, b, e}, 32'h1);
    chk(n_req == r0, "R2 no memory access", 32'(n_req - r0), 0);
    chk(rx_ptr == 0, "R2 pointer zero", rx_ptr, 0);

    // sweep frame length over every buffer boundary, alternating modes
    for (int l = 1; l <= 34; l++) run_chain(l, l[0], '{4, 3, 8, 16});
    // zero-room descriptor in the middle
    run_chain(9, 1'b0, '{4, 0, 8, 16});
    run_chain(4, 1'b1, '{4, 0, 8, 16});
    // R1: truncation of long frames
    run_chain(70, 1'b1, '{40, 40, 8, 8});
    run_chain(64, 1'b0, '{40, 40, 8, 8});
    run_chain(65, 1'b0, '{30, 34, 8, 8});

    // R3: first descriptor not owned
    build_chain('{4, 3, 8, 16});
    wr32(daddr(0) + 4, 32'h0);
    cfg_mode = 3'd2;
    load_ptr(DBASE);
    send_frame(5);
    wait_cause(b, e);
    chk(e && !b, "R3 error cause first", {30'h0, b, e}, 32'h1);
    chk(mem[baddr(0)] == 8'hEE, "R3 no byte written first", 32'(mem[baddr(0)]), 32'hEE);
    chk(rx_ptr == DBASE, "R3 pointer held", rx_ptr, DBASE);

    // R3: second descriptor not owned
    build_chain('{4, 3, 8, 16});
    wr32(daddr(1) + 4, 32'h0);
    load_ptr(DBASE);
    send_frame(6);
    wait_cause(b, e);
    chk(e && !b, "R3 error cause second", {30'h0, b, e}, 32'h1);
    chk(mem[baddr(1)] == 8'hEE, "R3 no byte written second", 32'(mem[baddr(1)]), 32'hEE);
    chk(rd32(daddr(0) + 4) == OWN, "R3 first not written", rd32(daddr(0) + 4), OWN);

    // R10: UART mode, each byte a frame
    build_chain('{4, 4, 4, 4});
    cfg_mode = 3'd4;
    load_ptr(DBASE);
    for (int k = 0; k < 3; k++) begin
      push_byte(8'(8'h50 + k), 1'b0);
      wait_cause(b, e);
      chk(b && !e, "R10 uart frame cause", {30'h0, b, e}, 32'h2);
      chk(rd32(daddr(k)) == 32'h0004_0001, "R10 uart size word", rd32(daddr(k)), 32'h0004_0001);
      chk(rd32(daddr(k) + 4) == 32'h0003_0000, "R10 uart status", rd32(daddr(k) + 4), 32'h0003_0000);
      chk(mem[baddr(k)] == 8'(8'h50 + k), "R10 uart byte", 32'(mem[baddr(k)]), 32'(8'h50 + k));
      chk(rx_ptr == 32'(daddr(k + 1)), "R10 uart pointer", rx_ptr, 32'(daddr(k + 1)));
    end

    // the engine recovers after errors: a plain frame still lands
    run_chain(10, 1'b1, '{4, 3, 8, 16});
    finish_run();
  end
endmodule